// File: doc/BRIEF.md
# LCD Multiplex Row-Scan Timer

This block produces the row-scan timing for a passive-matrix LCD that has separate segment and common drivers. As the master of a multi-chip panel, it divides its own clock into a line clock. From each line period it derives the line address used to read the display RAM, a polarity signal that inverts the drive every frame, and a start pulse for the common driver. At every line step it captures one full row of segment data into an output latch. The panel's pad cells drive the timing pins through separate output-enable signals.

As a slave, the block drives none of the shared timing pins. It samples the master's line clock, polarity and display-off signals through two-flop synchronizers. Each rising line-clock edge advances its line address. Each polarity change pulls the address back to line 1, so the slave scans in step with the master. Scan-out only reads the RAM port, so it does not interact with processor writes to the RAM on other ports.

Top module: `lcd_scan_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the line address becomes 1, `fr_o` becomes 0, `dyo_o` is 0 and the segment latch is cleared to all zeros.
- R2: In master mode (`master`=1) the line address advances exactly once every DIV clock cycles (default 16). `cl_o` is high for the first DIV/2 cycles of each line period, starting on the cycle the address changes, and low for the rest.
- R3: The line address runs 1, 2, … LINES (default 33) and then wraps to 1, so one frame spans LINES line periods.
- R4: At each line step the latch captures `seg_row_i` as it was in the cycle before the step. It holds that value until the next step, whatever `seg_row_i` does in between.
- R5: In master mode `fr_o` inverts exactly when the address wraps from LINES to 1, so one polarity cycle spans two frames.
- R6: In master mode `dyo_o` is high for the whole line period in which the address equals LINES and is low otherwise, so its falling edge coincides with the `fr_o` inversion.
- R7: In master mode `cl_oe`, `fr_oe`, `dyo_oe` and `dof_n_oe` are all 1, and `dof_n_o` equals `disp_on_i`.
- R8: In slave mode (`master`=0) all four output enables are 0, `dyo_o` is 0 and the internal divider is idle.
- R9: In slave mode a rising edge on `cl_i` advances the line address on the third clock edge after the change, with the same wrap as R3, and loads the latch as in R4.
- R10: In slave mode any change of `fr_i` sets the line address to 1 on the third clock edge after the change. It overrides a step that falls on the same cycle.
- R11: When the display is off, `seg_row_o` is all zeros while the latch and line counter keep running. In master mode "off" means `disp_on_i`=0, and it takes effect in the same cycle. In slave mode it means `dof_n_i`=0, seen after two clock edges. When the display is switched back on, the latched row reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| master | input | 1 | 1 = master role, 0 = slave role |
| disp_on_i | input | 1 | Display enable for the master (0 blanks the segments) |
| seg_row_i | input | SEG_W | Row of segment data read from the display RAM |
| cl_i | input | 1 | Line clock from the master (slave mode) |
| fr_i | input | 1 | Polarity signal from the master (slave mode) |
| dof_n_i | input | 1 | Display-off from the master, active low (slave mode) |
| line_addr_o | output | LW | Current line address, 1 to LINES |
| seg_row_o | output | SEG_W | Latched segment row, zero when blanked |
| cl_o | output | 1 | Line clock output |
| cl_oe | output | 1 | Pad enable for cl_o |
| fr_o | output | 1 | Frame polarity output |
| fr_oe | output | 1 | Pad enable for fr_o |
| dyo_o | output | 1 | Common-driver start pulse |
| dyo_oe | output | 1 | Pad enable for dyo_o (0 = high impedance) |
| dof_n_o | output | 1 | Display-off output, active low |
| dof_n_oe | output | 1 | Pad enable for dof_n_o |

## Verification
In master mode the address, polarity, start pulse and latch all change on the edge that ends the DIV-th cycle of a line period. The bench therefore counts edges from the release of reset and samples one cycle before and exactly at each expected change: cycle 16 for the first step, 528 for the first wrap and polarity flip. Blanking in master mode is combinational, so it is checked a nanosecond after the input moves. In slave mode every external input passes two synchronizer flops and, for clock and polarity, one edge detector. The bench drives the change at a falling edge, confirms that nothing has moved after two rising edges, and expects the result after the third (after the second for the display-off input).

// File: rtl/lcd_scan_timer.sv
`timescale 1ns/1ps
module lcd_scan_timer #(
  parameter int SEG_W = 100,
  parameter int LINES = 33,
  parameter int DIV   = 16,
  localparam int LW   = $clog2(LINES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic             disp_on_i,
  input  logic [SEG_W-1:0] seg_row_i,
  input  logic             cl_i,
  input  logic             fr_i,
  input  logic             dof_n_i,
  output logic [LW-1:0]    line_addr_o,
  output logic [SEG_W-1:0] seg_row_o,
  output logic             cl_o,
  output logic             cl_oe,
  output logic             fr_o,
  output logic             fr_oe,
  output logic             dyo_o,
  output logic             dyo_oe,
  output logic             dof_n_o,
  output logic             dof_n_oe
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [LW-1:0] LAST = LW'(LINES);
  localparam logic [LW-1:0] FIRST = LW'(1);

  logic [DW-1:0]    div_cnt;
  logic [LW-1:0]    line;
  logic             fr;
  logic [SEG_W-1:0] row_q;
  logic [2:0]       cl_sy, fr_sy;
  logic [1:0]       dof_sy;

  wire m_tick  = master && (div_cnt == DW'(DIV - 1));
  wire s_step  = !master && cl_sy[1] && !cl_sy[2];
  wire s_frchg = !master && (fr_sy[1] ^ fr_sy[2]);
  wire step    = m_tick || s_step;
  wire at_last = (line == LAST);
  wire disp_on = master ? disp_on_i : dof_sy[1];

  always_ff @(posedge clk) begin
    if (rst || !master)        div_cnt <= '0;
    else if (div_cnt == DW'(DIV - 1)) div_cnt <= '0;
    else                       div_cnt <= div_cnt + DW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cl_sy  <= '0;
      fr_sy  <= '0;
      dof_sy <= '1;
    end else begin
      cl_sy  <= {cl_sy[1:0], cl_i};
      fr_sy  <= {fr_sy[1:0], fr_i};
      dof_sy <= {dof_sy[0], dof_n_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || s_frchg) line <= FIRST;
    else if (step)      line <= at_last ? FIRST : line + FIRST;
  end

  always_ff @(posedge clk) begin
    if (rst)                    fr <= 1'b0;
    else if (!master)           fr <= fr_sy[1];
    else if (m_tick && at_last) fr <= ~fr;
  end

  always_ff @(posedge clk) begin
    if (rst)       row_q <= '0;
    else if (step) row_q <= seg_row_i;
  end

  assign line_addr_o = line;
  assign seg_row_o   = disp_on ? row_q : '0;
  assign cl_o        = master && (div_cnt < DW'(DIV / 2));
  assign fr_o        = fr;
  assign dyo_o       = master && at_last;
  assign dof_n_o     = master && disp_on_i;
  assign cl_oe       = master;
  assign fr_oe       = master;
  assign dyo_oe      = master;
  assign dof_n_oe    = master;

  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (line >= FIRST) && (line <= LAST)); // R3
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !s_frchg) |=> (line == (($past(line) == LAST) ? FIRST : $past(line) + FIRST))); // R3
  AST_FR_FLIP: assert property (@(posedge clk) disable iff (rst)
    (m_tick && at_last) |=> (fr != $past(fr))); // R5
  AST_FR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (master && !(m_tick && at_last)) |=> $stable(fr)); // R5
  AST_ROW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    step |=> (row_q == $past(seg_row_i))); // R4
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !master |-> (!cl_oe && !fr_oe && !dyo_oe && !dof_n_oe && !dyo_o)); // R8
  AST_RESYNC: assert property (@(posedge clk) disable iff (rst)
    s_frchg |=> (line == FIRST)); // R10
endmodule

// File: tb/tb_lcd_scan_timer.sv
`timescale 1ns/1ps
module tb_lcd_scan_timer;
  localparam int SEG_W = 100;
  localparam int LINES = 33;
  localparam int DIV   = 16;
  localparam int LW    = $clog2(LINES + 1);

  logic clk = 0, rst = 1, master = 1, disp_on_i = 1;
  logic [SEG_W-1:0] seg_row_i = '0;
  logic cl_i = 0, fr_i = 0, dof_n_i = 1;
  logic [LW-1:0] line_addr_o;
  logic [SEG_W-1:0] seg_row_o;
  logic cl_o, cl_oe, fr_o, fr_oe, dyo_o, dyo_oe, dof_n_o, dof_n_oe;

  int total = 0, bad = 0, cyc = 0;

  localparam logic [SEG_W-1:0] P1 = {25{4'h9}};
  localparam logic [SEG_W-1:0] P2 = {25{4'h6}};
  localparam logic [SEG_W-1:0] P3 = {50{2'b10}};

  lcd_scan_timer #(.SEG_W(SEG_W), .LINES(LINES), .DIV(DIV)) dut (
    .clk(clk), .rst(rst), .master(master), .disp_on_i(disp_on_i),
    .seg_row_i(seg_row_i), .cl_i(cl_i), .fr_i(fr_i), .dof_n_i(dof_n_i),
    .line_addr_o(line_addr_o), .seg_row_o(seg_row_o),
    .cl_o(cl_o), .cl_oe(cl_oe), .fr_o(fr_o), .fr_oe(fr_oe),
    .dyo_o(dyo_o), .dyo_oe(dyo_oe), .dof_n_o(dof_n_o), .dof_n_oe(dof_n_oe));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic oes(input logic [3:0] exp, input string req);
    chk(req, {cl_oe, fr_oe, dyo_oe, dof_n_oe}, exp);
  endtask

  task automatic t_reset(input logic m);
    @(negedge clk);
    master = m; rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 line", line_addr_o, 1);
    chk("R1 fr", fr_o, 0);
    chk("R1 dyo", dyo_o, 0);
    chk("R1 seg", seg_row_o, 0);
    rst = 0;
  endtask

  task automatic t_master_div;
    chk("R2 cl high at start", cl_o, 1);
    oes(4'b1111, "R7 enables");
    wait_to(8);  chk("R2 cl low half", cl_o, 0);
    wait_to(15); chk("R2 no early step", line_addr_o, 1);
    wait_to(16); chk("R2 step at DIV", line_addr_o, 2);
    chk("R2 cl rises with step", cl_o, 1);
  endtask

  task automatic t_latch;
    seg_row_i = P1;
    wait_to(32); chk("R4 capture P1", seg_row_o, P1);
    chk("R3 line 3", line_addr_o, 3);
    seg_row_i = P2;
    wait_to(40); chk("R4 hold P1", seg_row_o, P1);
    wait_to(48); chk("R4 capture P2", seg_row_o, P2);
  endtask

  task automatic t_frame;
    wait_to(32 * DIV);
    chk("R3 last line", line_addr_o, LINES);
    chk("R6 dyo high", dyo_o, 1);
    chk("R5 fr before wrap", fr_o, 0);
    wait_to(33 * DIV - 1);
    chk("R6 dyo still high", dyo_o, 1);
    chk("R5 fr not yet", fr_o, 0);
    wait_to(33 * DIV);
    chk("R3 wrap to 1", line_addr_o, 1);
    chk("R5 fr flips", fr_o, 1);
    chk("R6 dyo falls", dyo_o, 0);
    wait_to(33 * DIV + 8);
    chk("R6 dyo low mid-frame", dyo_o, 0);
    wait_to(66 * DIV - 1);
    chk("R5 fr held for frame", fr_o, 1);
    wait_to(66 * DIV);
    chk("R5 fr back after two frames", fr_o, 0);
  endtask

  task automatic t_master_blank;
    seg_row_i = P3;
    wait_to(66 * DIV + DIV);
    chk("R4 capture P3", seg_row_o, P3);
    disp_on_i = 0; #1;
    chk("R11 master blank", seg_row_o, 0);
    chk("R7 dof out", dof_n_o, 0);
    wait_to(66 * DIV + 2 * DIV);
    chk("R11 counter runs while blank", line_addr_o, 3);
    chk("R11 still blank", seg_row_o, 0);
    disp_on_i = 1; #1;
    chk("R11 row returns", seg_row_o, P3);
    chk("R7 dof out on", dof_n_o, 1);
  endtask

  task automatic slave_step(input logic [LW-1:0] exp, input string req);
    cl_i = 1;
    repeat (2) @(negedge clk);
    chk({req, " no early"}, line_addr_o, (exp == 1) ? LINES : exp - 1);
    @(negedge clk);
    chk(req, line_addr_o, exp);
    cl_i = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_slave;
    cl_i = 0; fr_i = 0; dof_n_i = 1;
    t_reset(0);
    oes(4'b0000, "R8 enables off");
    chk("R8 dyo low", dyo_o, 0);
    seg_row_i = P1;
    repeat (4) @(negedge clk);
    chk("R8 cl out idle", cl_o, 0);
    slave_step(2, "R9 step");
    chk("R9 latch", seg_row_o, P1);
    slave_step(3, "R9 step 3");
    slave_step(4, "R9 step 4");
    fr_i = 1;
    repeat (2) @(negedge clk);
    chk("R10 not yet", line_addr_o, 4);
    @(negedge clk);
    chk("R10 resync", line_addr_o, 1);
    repeat (3) @(negedge clk);
    chk("R10 held fr no reset", line_addr_o, 1);
    slave_step(2, "R9 after resync");
    chk("R8 dyo low after steps", dyo_o, 0);
    dof_n_i = 0;
    @(negedge clk);
    chk("R11 slave not yet", seg_row_o, P1);
    @(negedge clk);
    chk("R11 slave blank", seg_row_o, 0);
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset(1);
    t_master_div;
    t_latch;
    t_frame;
    t_master_blank;
    t_slave;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule